// File: doc/BRIEF.md
# Access Protection Checker

This block decides whether a single memory access is allowed by the legacy segment rules and by the permission bits of the page entry that matched it. For each access it is given the segment in use (index, selector, base, limit, readable, writable and expand-down attributes), the default operand-size bit of the code segment, the machine mode bits, the privilege level and the properties of the access. It returns one of three outcomes: pass, a general-protection fault with error code zero, or a page fault that carries the faulting linear address and its flag bits.

All checking is combinational. The outcome is captured in registers when `in_valid` is high and appears one clock later with a one-cycle `res_valid` pulse. When a segment fault and a page fault occur together, the segment fault is reported. The page-table storage, the walker and the descriptor loading are outside this block. Their results reach it as plain inputs.

Top module: `acc_prot_chk`

## Requirements
- R1: While reset is asserted and after reset is released, `res_valid` is 0, `res_kind` is 0, and `res_pf_flags` and `res_fault_addr` are 0 until the first valid access.
- R2: An access presented with `in_valid` high produces its result on the outputs in the next cycle, with `res_valid` high for that one cycle. In cycles without `in_valid`, `res_valid` is 0 and the result outputs keep their last values, whatever the other inputs do.
- R3: The segment checks apply only when `prot_en` is 1 and `long_mode` is 0. In every other mode the segment stage never faults.
- R4: A selector of zero raises a general-protection fault for segment indices 0 to 5 and 10 to 15. Indices 6, 7, 8 and 9 are exempt from this rule.
- R5: For segment indices 0 to 6 only, a general-protection fault is raised when `is_write` or `store_chk` is 1 and `seg_wr` is 0, or when `is_write` is 0 and `seg_rd` is 0.
- R6: The offset is (`lin_addr` − `seg_base`) modulo 2^ADDR_W. It is further truncated to its low SHORT_W bits when `cs_def32` equals `asize_ovr`. The end offset is offset + `acc_size` − 1, computed without wrap.
- R7: For a segment that is not expand-down, a general-protection fault is raised when the offset or the end offset is greater than `seg_limit`.
- R8: For an expand-down segment (`seg_xdown` is 1 and the index is 0 to 6), a general-protection fault is raised when the offset or the end offset is less than or equal to `seg_limit`.
- R9: The page checks apply only when `paging_en` is 1. An access is a user access when `cpl` is 3 and `force_sup` is 0.
- R10: A page fault (`res_kind` = 2) is raised for a user access when `pg_user` is 0, or for a write (`is_write` = 1) when `pg_wr` is 0. `res_pf_flags` bit 0 is present (always 1), bit 1 is write and bit 2 is user. `res_fault_addr` is `lin_addr`.
- R11: A general-protection fault (`res_kind` = 1) takes priority over a page fault and reports flags 0 and address 0. A passing access reports kind 0, flags 0 and address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Access present this cycle |
| seg_idx | input | 4 | Segment index |
| seg_sel | input | SEL_W | Segment selector value |
| seg_base | input | ADDR_W | Segment base |
| seg_limit | input | ADDR_W | Segment limit |
| seg_rd | input | 1 | Segment readable |
| seg_wr | input | 1 | Segment writable |
| seg_xdown | input | 1 | Segment expands downward |
| cs_def32 | input | 1 | Code segment default size is wide |
| prot_en | input | 1 | Protected mode on |
| long_mode | input | 1 | 64-bit long mode active |
| paging_en | input | 1 | Paging on |
| cpl | input | 2 | Current privilege level |
| is_write | input | 1 | Access is a write |
| store_chk | input | 1 | Read that must also pass the write check |
| asize_ovr | input | 1 | Address-size override |
| force_sup | input | 1 | Treat access as supervisor |
| lin_addr | input | ADDR_W | Linear address |
| acc_size | input | SIZE_W | Access size in bytes (1 or more) |
| pg_user | input | 1 | Page allows user access |
| pg_wr | input | 1 | Page allows writes |
| res_valid | output | 1 | Result valid pulse |
| res_kind | output | 2 | 0 pass, 1 general protection, 2 page fault |
| res_pf_flags | output | 3 | Page-fault flags {user, write, present} |
| res_fault_addr | output | ADDR_W | Faulting linear address |

## Verification
The bench builds the checker with ADDR_W = 12, SHORT_W = 6, SIZE_W = 3 and SEL_W = 4. With these values the 16-bit wrap shrinks to 64 bytes and the whole address space to 4096 bytes. A sweep over addresses, bases and limits can therefore reach offsets that wrap in the narrow mode, end offsets that cross the limit, and limits at zero and at the top of the space, in both the normal and the expand-down sense. The rule and page sweeps cover every segment index, every combination of attribute and access flags, and every privilege level, with segment and page faults raised together.

// File: rtl/apc_pkg.sv
package apc_pkg;
  typedef enum logic [1:0] {
    FK_NONE = 2'd0,
    FK_GP   = 2'd1,
    FK_PF   = 2'd2
  } fault_kind_e;

  localparam int SEG_IDX_W     = 4;
  localparam int SEG_ATTR_MAX  = 6;
  localparam int SEG_EXEMPT_LO = 6;
  localparam int SEG_EXEMPT_HI = 9;

  localparam int PF_FLAGS_W     = 3;
  localparam int PF_PRESENT_BIT = 0;
  localparam int PF_WRITE_BIT   = 1;
  localparam int PF_USER_BIT    = 2;
endpackage

// File: rtl/apc_seg_rules.sv
module apc_seg_rules
  import apc_pkg::*;
#(
  parameter int SEL_W = 16
) (
  input  logic [SEG_IDX_W-1:0] seg_idx,
  input  logic [SEL_W-1:0]     seg_sel,
  input  logic                 seg_rd,
  input  logic                 seg_wr,
  input  logic                 is_write,
  input  logic                 store_chk,
  output logic                 attr_applies,
  output logic                 rule_fault
);
  logic null_exempt;
  logic null_fault;
  logic wr_fault;
  logic rd_fault;

  always_comb begin
    null_exempt  = (int'(seg_idx) >= SEG_EXEMPT_LO) && (int'(seg_idx) <= SEG_EXEMPT_HI);
    attr_applies = int'(seg_idx) <= SEG_ATTR_MAX;
    null_fault   = !null_exempt && (seg_sel == '0);
    wr_fault     = attr_applies && !seg_wr && (is_write || store_chk);
    rd_fault     = attr_applies && !seg_rd && !is_write;
    rule_fault   = null_fault || wr_fault || rd_fault;
  end
endmodule

// File: rtl/apc_seg_bounds.sv
module apc_seg_bounds #(
  parameter int ADDR_W  = 32,
  parameter int SHORT_W = 16,
  parameter int SIZE_W  = 4
) (
  input  logic [ADDR_W-1:0] lin_addr,
  input  logic [ADDR_W-1:0] seg_base,
  input  logic [ADDR_W-1:0] seg_limit,
  input  logic [SIZE_W-1:0] acc_size,
  input  logic              narrow,
  input  logic              xdown,
  output logic              bound_fault
);
  localparam int EXT_W = ADDR_W + 1;

  logic [ADDR_W-1:0] diff;
  logic [ADDR_W-1:0] off;
  logic [EXT_W-1:0]  end_off;
  logic [EXT_W-1:0]  lim_ext;
  logic              off_above;
  logic              end_above;

  assign diff = lin_addr - seg_base;

  generate
    if (SHORT_W < ADDR_W) begin : g_wrap
      assign off = narrow ? {{(ADDR_W-SHORT_W){1'b0}}, diff[SHORT_W-1:0]} : diff;
    end else begin : g_nowrap
      logic unused_narrow;
      assign unused_narrow = narrow;
      assign off = diff;
    end
  endgenerate

  always_comb begin
    lim_ext   = {1'b0, seg_limit};
    end_off   = {1'b0, off} + EXT_W'(acc_size) - EXT_W'(1);
    off_above = {1'b0, off} > lim_ext;
    end_above = end_off > lim_ext;
    if (xdown) bound_fault = !off_above || !end_above;
    else       bound_fault = off_above || end_above;
  end
endmodule

// File: rtl/apc_page_rules.sv
module apc_page_rules
  import apc_pkg::*;
(
  input  logic                  paging_en,
  input  logic [1:0]            cpl,
  input  logic                  force_sup,
  input  logic                  is_write,
  input  logic                  pg_user,
  input  logic                  pg_wr,
  output logic                  pg_fault,
  output logic [PF_FLAGS_W-1:0] pf_flags
);
  logic user_acc;

  always_comb begin
    user_acc = (cpl == 2'd3) && !force_sup;
    pg_fault = paging_en && ((user_acc && !pg_user) || (is_write && !pg_wr));
    pf_flags = '0;
    pf_flags[PF_PRESENT_BIT] = 1'b1;
    pf_flags[PF_WRITE_BIT]   = is_write;
    pf_flags[PF_USER_BIT]    = user_acc;
  end
endmodule

// File: rtl/acc_prot_chk.sv
module acc_prot_chk
  import apc_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int SHORT_W = 16,
  parameter int SIZE_W  = 4,
  parameter int SEL_W   = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic [3:0]           seg_idx,
  input  logic [SEL_W-1:0]     seg_sel,
  input  logic [ADDR_W-1:0]    seg_base,
  input  logic [ADDR_W-1:0]    seg_limit,
  input  logic                 seg_rd,
  input  logic                 seg_wr,
  input  logic                 seg_xdown,
  input  logic                 cs_def32,
  input  logic                 prot_en,
  input  logic                 long_mode,
  input  logic                 paging_en,
  input  logic [1:0]           cpl,
  input  logic                 is_write,
  input  logic                 store_chk,
  input  logic                 asize_ovr,
  input  logic                 force_sup,
  input  logic [ADDR_W-1:0]    lin_addr,
  input  logic [SIZE_W-1:0]    acc_size,
  input  logic                 pg_user,
  input  logic                 pg_wr,
  output logic                 res_valid,
  output logic [1:0]           res_kind,
  output logic [2:0]           res_pf_flags,
  output logic [ADDR_W-1:0]    res_fault_addr
);
  logic                  attr_applies_w;
  logic                  rule_fault_w;
  logic                  bound_fault_w;
  logic                  pg_fault_w;
  logic [PF_FLAGS_W-1:0] pf_flags_w;
  logic                  seg_active;
  logic                  narrow_w;
  logic                  xdown_w;
  logic                  seg_fault_w;

  fault_kind_e           kind_nxt;
  logic [PF_FLAGS_W-1:0] flags_nxt;
  logic [ADDR_W-1:0]     addr_nxt;
  fault_kind_e           kind_q;

  apc_seg_rules #(.SEL_W(SEL_W)) u_rules (
    .seg_idx      (seg_idx),
    .seg_sel      (seg_sel),
    .seg_rd       (seg_rd),
    .seg_wr       (seg_wr),
    .is_write     (is_write),
    .store_chk    (store_chk),
    .attr_applies (attr_applies_w),
    .rule_fault   (rule_fault_w)
  );

  apc_seg_bounds #(.ADDR_W(ADDR_W), .SHORT_W(SHORT_W), .SIZE_W(SIZE_W)) u_bounds (
    .lin_addr    (lin_addr),
    .seg_base    (seg_base),
    .seg_limit   (seg_limit),
    .acc_size    (acc_size),
    .narrow      (narrow_w),
    .xdown       (xdown_w),
    .bound_fault (bound_fault_w)
  );

  apc_page_rules u_page (
    .paging_en (paging_en),
    .cpl       (cpl),
    .force_sup (force_sup),
    .is_write  (is_write),
    .pg_user   (pg_user),
    .pg_wr     (pg_wr),
    .pg_fault  (pg_fault_w),
    .pf_flags  (pf_flags_w)
  );

  // Next-state logic: segment stage gating and fault priority.
  always_comb begin
    seg_active  = prot_en && !long_mode;
    narrow_w    = ~(cs_def32 ^ asize_ovr);
    xdown_w     = seg_xdown && attr_applies_w;
    seg_fault_w = seg_active && (rule_fault_w || bound_fault_w);
    kind_nxt    = FK_NONE;
    flags_nxt   = '0;
    addr_nxt    = '0;
    if (seg_fault_w) begin
      kind_nxt = FK_GP;
    end else if (pg_fault_w) begin
      kind_nxt  = FK_PF;
      flags_nxt = pf_flags_w;
      addr_nxt  = lin_addr;
    end
  end

  // Result registers, loaded only on a valid access.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid      <= 1'b0;
      kind_q         <= FK_NONE;
      res_pf_flags   <= '0;
      res_fault_addr <= '0;
    end else begin
      res_valid <= in_valid;
      if (in_valid) begin
        kind_q         <= kind_nxt;
        res_pf_flags   <= flags_nxt;
        res_fault_addr <= addr_nxt;
      end
    end
  end

  assign res_kind = kind_q;

  AST_SEG_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!prot_en || long_mode) |-> !seg_fault_w); // R3
  AST_NULL_SEL_GP: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && prot_en && !long_mode && seg_sel == '0 && seg_idx < 4'd6)
      |=> res_kind == FK_GP); // R4
  AST_PAGE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !paging_en |-> !pg_fault_w); // R9
  AST_VALID_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> res_valid); // R2
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!res_valid && $stable(res_kind) && $stable(res_fault_addr))); // R2
  AST_PF_PRESENT: assert property (@(posedge clk) disable iff (!rst_n)
    res_kind == FK_PF |-> res_pf_flags[PF_PRESENT_BIT]); // R10
  AST_GP_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    res_kind != FK_PF |-> (res_pf_flags == '0 && res_fault_addr == '0)); // R11
endmodule

// File: tb/acc_prot_chk_tb.sv
module acc_prot_chk_tb;
  localparam int AW = 12;
  localparam int SW = 6;
  localparam int ZW = 3;
  localparam int LW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [3:0] seg_idx = '0;
  logic [LW-1:0] seg_sel = '0;
  logic [AW-1:0] seg_base = '0, seg_limit = '0, lin_addr = '0;
  logic seg_rd = 1'b0, seg_wr = 1'b0, seg_xdown = 1'b0, cs_def32 = 1'b0;
  logic prot_en = 1'b0, long_mode = 1'b0, paging_en = 1'b0;
  logic [1:0] cpl = '0;
  logic is_write = 1'b0, store_chk = 1'b0, asize_ovr = 1'b0, force_sup = 1'b0;
  logic [ZW-1:0] acc_size = 3'd1;
  logic pg_user = 1'b0, pg_wr = 1'b0;
  logic res_valid;
  logic [1:0] res_kind;
  logic [2:0] res_pf_flags;
  logic [AW-1:0] res_fault_addr;

  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  acc_prot_chk #(.ADDR_W(AW), .SHORT_W(SW), .SIZE_W(ZW), .SEL_W(LW)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .seg_idx(seg_idx),
    .seg_sel(seg_sel), .seg_base(seg_base), .seg_limit(seg_limit),
    .seg_rd(seg_rd), .seg_wr(seg_wr), .seg_xdown(seg_xdown),
    .cs_def32(cs_def32), .prot_en(prot_en), .long_mode(long_mode),
    .paging_en(paging_en), .cpl(cpl), .is_write(is_write),
    .store_chk(store_chk), .asize_ovr(asize_ovr), .force_sup(force_sup),
    .lin_addr(lin_addr), .acc_size(acc_size), .pg_user(pg_user),
    .pg_wr(pg_wr), .res_valid(res_valid), .res_kind(res_kind),
    .res_pf_flags(res_pf_flags), .res_fault_addr(res_fault_addr)
  );

  // Expected result from the requirements: {valid, kind, flags, addr}
  function automatic logic [AW+5:0] expect_result();
    logic [AW-1:0] diff;
    int off, endo, lim;
    bit attr, exempt, gp, pf, user;
    diff   = lin_addr - seg_base;
    off    = (cs_def32 == asize_ovr) ? int'(diff) % (1 << SW) : int'(diff);
    endo   = off + int'(acc_size) - 1;
    lim    = int'(seg_limit);
    attr   = seg_idx <= 4'd6;
    exempt = (seg_idx >= 4'd6) && (seg_idx <= 4'd9);
    gp = 0;
    if (prot_en && !long_mode) begin
      if (!exempt && seg_sel == 0) gp = 1;
      if (attr && !seg_wr && (is_write || store_chk)) gp = 1;
      if (attr && !seg_rd && !is_write) gp = 1;
      if (attr && seg_xdown) begin
        if (off <= lim || endo <= lim) gp = 1;
      end else begin
        if (off > lim || endo > lim) gp = 1;
      end
    end
    user = (cpl == 2'd3) && !force_sup;
    pf = paging_en && ((user && !pg_user) || (is_write && !pg_wr));
    if (gp) return {1'b1, 2'd1, 3'd0, {AW{1'b0}}};
    if (pf) return {1'b1, 2'd2, {user, is_write, 1'b1}, lin_addr};
    return {1'b1, 2'd0, 3'd0, {AW{1'b0}}};
  endfunction

  task automatic check(input string tag, input logic [AW+5:0] got, input logic [AW+5:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic run(input string tag);
    logic [AW+5:0] exp;
    @(negedge clk);
    exp = expect_result();
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check(tag, {res_valid, res_kind, res_pf_flags, res_fault_addr}, exp);
  endtask

  initial begin
    #750000;
    failures++;
    $display("FAIL R2 watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [AW+5:0] held;
    repeat (3) @(negedge clk);
    check("R1 in reset", {res_valid, res_kind, res_pf_flags, res_fault_addr}, '0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", {res_valid, res_kind, res_pf_flags, res_fault_addr}, '0);

    // Offset width, normal and expand-down limits
    prot_en = 1; long_mode = 0; paging_en = 0; seg_idx = 4'd2; seg_sel = 4'd3;
    seg_rd = 1; seg_wr = 1; is_write = 0; store_chk = 0;
    for (int m = 0; m < 16; m++) begin
      cs_def32 = m[0]; asize_ovr = m[1]; seg_xdown = m[2];
      seg_base = m[3] ? 12'h7F0 : 12'h000;
      for (int a = 0; a < 4096; a += 373) begin
        lin_addr = AW'(a);
        for (int l = 0; l < 6; l++) begin
          case (l)
            0: seg_limit = 12'h000;
            1: seg_limit = 12'h005;
            2: seg_limit = 12'h03F;
            3: seg_limit = 12'h040;
            4: seg_limit = 12'h7FF;
            default: seg_limit = 12'hFFF;
          endcase
          for (int s = 1; s < 8; s++) begin
            acc_size = ZW'(s);
            run("R6 R7 R8 bounds");
          end
        end
      end
    end

    // Selector, attribute and mode rules
    seg_base = 0; lin_addr = 0; seg_limit = 12'hFFF; acc_size = 1; seg_xdown = 0;
    cs_def32 = 1; asize_ovr = 0;
    for (int i = 0; i < 16; i++) begin
      for (int v = 0; v < 128; v++) begin
        seg_idx = 4'(i);
        seg_sel = v[0] ? 4'd5 : 4'd0;
        seg_rd = v[1]; seg_wr = v[2]; is_write = v[3]; store_chk = v[4];
        prot_en = v[5]; long_mode = v[6];
        run("R3 R4 R5 rules");
      end
    end

    // Page checks and priority
    seg_rd = 1; seg_wr = 1; seg_idx = 0; long_mode = 0; store_chk = 0;
    for (int p = 0; p < 256; p++) begin
      paging_en = p[0]; cpl = p[2:1]; force_sup = p[3]; is_write = p[4];
      pg_user = p[5]; pg_wr = p[6];
      prot_en = p[7]; seg_sel = p[7] ? 4'd0 : 4'd1;
      lin_addr = AW'(p * 37 + 1);
      run("R9 R10 R11 page");
    end

    // Hold without valid
    prot_en = 0; paging_en = 1; cpl = 3; force_sup = 0; pg_user = 0; is_write = 1; pg_wr = 0;
    lin_addr = 12'hABC;
    run("R10 setup");
    held = {1'b0, res_kind, res_pf_flags, res_fault_addr};
    lin_addr = 12'h123; paging_en = 0; prot_en = 1; seg_sel = 0;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check("R2 hold", {res_valid, res_kind, res_pf_flags, res_fault_addr}, held);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule